// File: doc/BRIEF.md
# Field-Tagged Instruction Decoder With Pair Check

This block decodes two 16-bit instruction words at the same time. The words have no fixed opcode field. Each word has four 4-bit fields, and the top bit of each field marks it as either an opcode fragment or a register reference. For each slot the decoder gives out:
- the tag pattern;
- a packed opcode value;
- the number of register operands;
- the set of registers the instruction reads;
- the set of registers the instruction writes.

A word decodes on its own. No prefix exists and nothing is carried from one word to the next.

The block also decides whether the two words can issue in the same cycle. It compares the registers written by the older word (slot A) with the registers read and written by the younger word (slot B). It raises a dependency flag on a read-after-write overlap. It grants dual issue only when the two words are fully independent.

The decode is combinational. One register stage follows it, so every result appears on the outputs in the cycle after the words were presented.

Top module: `tagged_pair_decoder`

## Requirements
- R1: Field i occupies bits 4i+3..4i (field 3 is bits 15:12, field 0 is bits 3:0). Tag output bit i equals bit 4i+3. A set tag marks an opcode field; a clear tag marks a register field whose register number is bits 4i+2..4i.
- R2: The opcode output is 12 bits wide. The low 3 bits of each opcode field are concatenated, starting from field 3 downward, and left-aligned in the 12 bits. Unused low bits are zero, so an all-register word gives 0.
- R3: The register count output equals the number of register fields, from 0 to 4.
- R4: When a word has at least one opcode field, the reference point is the lowest-numbered opcode field. Register fields numbered above it are inputs and go into the read set. Register fields numbered below it are outputs and go into the write set. Both sets are 8-bit masks, and bit n stands for register n.
- R5: A word with no opcode field (all four tags clear) reads the registers in fields 3 and 2 and writes the registers in fields 1 and 0.
- R6: A word with exactly one register field has that register in both its read set and its write set.
- R7: All outputs are registered and reflect the inputs sampled at the previous rising clock edge. While reset is low, every output is zero. For a slot whose valid input was low, the decoded valid output is 0 and the tag, opcode, count and both sets are all zero.
- R8: The dependency flag is 1 exactly when both slots are valid and slot A's write set shares a register with slot B's read set.
- R9: Dual issue is 1 exactly when both slots are valid and there is no read-after-write overlap and no write-write overlap (slot A's write set shares no register with slot B's write set).
- R10: The decode of a word does not depend on any earlier word. Identical inputs give identical outputs whatever came before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instrA | input | 16 | Older instruction word |
| validA | input | 1 | instrA is present |
| instrB | input | 16 | Younger instruction word |
| validB | input | 1 | instrB is present |
| decValidA | output | 1 | Slot A result is valid |
| tagA | output | 4 | Slot A field tags |
| opcodeA | output | 12 | Slot A packed opcode |
| regCountA | output | 3 | Slot A register operand count |
| readSetA | output | 8 | Slot A registers read |
| writeSetA | output | 8 | Slot A registers written |
| decValidB | output | 1 | Slot B result is valid |
| tagB | output | 4 | Slot B field tags |
| opcodeB | output | 12 | Slot B packed opcode |
| regCountB | output | 3 | Slot B register operand count |
| readSetB | output | 8 | Slot B registers read |
| writeSetB | output | 8 | Slot B registers written |
| depFlag | output | 1 | Read-after-write overlap from A to B |
| dualIssue | output | 1 | Both words may issue together |

## Verification
The bench aims at the following cases:
- The all-register word: a decoder that looked for an opcode split there would put every register in one set.
- The all-opcode word: it must give a full 12-bit opcode and empty sets.
- Words with a single register field: one that dropped the shared-register rule would leave the read set or the write set empty.
- Opcode fields separated by register fields: these show whether the packing left-aligns them in field order, or instead right-aligns or reorders them.

For pairing, directed pairs separate the three overlap cases:
- a read-after-write overlap, which must raise the dependency flag;
- a write-write overlap only, which must block dual issue without raising the dependency flag;
- an independent pair.

Pairs with one slot invalid catch a grant that ignores the valid bits. Random sequences then look for any state carried from one word to the next.

// File: rtl/tagged_pair_pkg.sv
package tagged_pair_pkg;

  // Strobes from the pairing control into the decode datapath.
  typedef struct packed {
    logic captureA;   // load slot A decode into the output stage
    logic captureB;   // load slot B decode into the output stage
    logic rawHit;     // A writes a register that B reads
    logic grantPair;  // both words may issue together
  } pairStrobes_t;

endpackage

// File: rtl/field_decoder.sv
module field_decoder #(
  parameter int FIELD_W    = 4,
  parameter int NUM_FIELDS = 4,
  localparam int REG_W    = FIELD_W - 1,
  localparam int NUM_REGS = 1 << REG_W,
  localparam int OPC_W    = NUM_FIELDS * REG_W,
  localparam int INSTR_W  = NUM_FIELDS * FIELD_W,
  localparam int CNT_W    = $clog2(NUM_FIELDS + 1)
) (
  input  logic [INSTR_W-1:0]    instr,
  output logic [NUM_FIELDS-1:0] tagOut,
  output logic [OPC_W-1:0]      opcodeOut,
  output logic [CNT_W-1:0]      regCountOut,
  output logic [NUM_REGS-1:0]   readSetOut,
  output logic [NUM_REGS-1:0]   writeSetOut
);

  localparam int HALF = NUM_FIELDS / 2;

  // R1: the top bit of each field is its tag
  always_comb begin
    tagOut = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      tagOut[i] = instr[i*FIELD_W + FIELD_W - 1];
    end
  end

  // R2: pack opcode fragments from the highest field down, then left-align
  logic [OPC_W-1:0] opcAcc;
  int               opCount;
  always_comb begin
    opcAcc  = '0;
    opCount = 0;
    for (int i = NUM_FIELDS - 1; i >= 0; i--) begin
      if (tagOut[i]) begin
        opcAcc  = {opcAcc[OPC_W-REG_W-1:0], instr[i*FIELD_W +: REG_W]};
        opCount = opCount + 1;
      end
    end
    opcodeOut = opcAcc << (REG_W * (NUM_FIELDS - opCount));
  end

  // Lowest-numbered opcode field: splits inputs from outputs (R4)
  int   lowestOp;
  logic hasOp;
  always_comb begin
    lowestOp = 0;
    hasOp    = 1'b0;
    for (int i = NUM_FIELDS - 1; i >= 0; i--) begin
      if (tagOut[i]) begin
        lowestOp = i;
        hasOp    = 1'b1;
      end
    end
  end

  // R3: register operand count
  int regTotal;
  always_comb begin
    regTotal = 0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (!tagOut[i]) regTotal = regTotal + 1;
    end
    regCountOut = CNT_W'(regTotal);
  end

  // R4, R5, R6: read and write sets
  logic [REG_W-1:0] regIdx;
  logic             isInput;
  logic             isOutput;
  always_comb begin
    readSetOut  = '0;
    writeSetOut = '0;
    regIdx      = '0;
    isInput     = 1'b0;
    isOutput    = 1'b0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (!tagOut[i]) begin
        regIdx = instr[i*FIELD_W +: REG_W];
        if (regTotal == 1) begin
          isInput  = 1'b1;
          isOutput = 1'b1;
        end else if (hasOp) begin
          isInput  = (i > lowestOp);
          isOutput = (i < lowestOp);
        end else begin
          isInput  = (i >= HALF);
          isOutput = (i < HALF);
        end
        if (isInput)  readSetOut[regIdx]  = 1'b1;
        if (isOutput) writeSetOut[regIdx] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/pair_control.sv
module pair_control
  import tagged_pair_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                validA,
  input  logic                validB,
  input  logic [NUM_REGS-1:0] writeSetA,
  input  logic [NUM_REGS-1:0] readSetB,
  input  logic [NUM_REGS-1:0] writeSetB,
  output pairStrobes_t        strobes
);

  logic bothValid;
  logic rawOverlap;
  logic wawOverlap;

  always_comb begin
    bothValid  = validA && validB;
    rawOverlap = |(writeSetA & readSetB);
    wawOverlap = |(writeSetA & writeSetB);

    strobes.captureA  = validA;
    strobes.captureB  = validB;
    strobes.rawHit    = bothValid && rawOverlap;                  // R8
    strobes.grantPair = bothValid && !rawOverlap && !wawOverlap;  // R9
  end

endmodule

// File: rtl/decode_datapath.sv
module decode_datapath
  import tagged_pair_pkg::*;
#(
  parameter int FIELD_W    = 4,
  parameter int NUM_FIELDS = 4,
  localparam int REG_W    = FIELD_W - 1,
  localparam int NUM_REGS = 1 << REG_W,
  localparam int OPC_W    = NUM_FIELDS * REG_W,
  localparam int INSTR_W  = NUM_FIELDS * FIELD_W,
  localparam int CNT_W    = $clog2(NUM_FIELDS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [INSTR_W-1:0]    instrA,
  input  logic [INSTR_W-1:0]    instrB,
  input  pairStrobes_t          strobes,
  // combinational sets for the pairing control
  output logic [NUM_REGS-1:0]   writeSetACmb,
  output logic [NUM_REGS-1:0]   readSetBCmb,
  output logic [NUM_REGS-1:0]   writeSetBCmb,
  // registered results
  output logic                  decValidA,
  output logic [NUM_FIELDS-1:0] tagA,
  output logic [OPC_W-1:0]      opcodeA,
  output logic [CNT_W-1:0]      regCountA,
  output logic [NUM_REGS-1:0]   readSetA,
  output logic [NUM_REGS-1:0]   writeSetA,
  output logic                  decValidB,
  output logic [NUM_FIELDS-1:0] tagB,
  output logic [OPC_W-1:0]      opcodeB,
  output logic [CNT_W-1:0]      regCountB,
  output logic [NUM_REGS-1:0]   readSetB,
  output logic [NUM_REGS-1:0]   writeSetB,
  output logic                  depFlag,
  output logic                  dualIssue
);

  localparam int NUM_SLOTS = 2;

  logic [INSTR_W-1:0]    slotInstr   [NUM_SLOTS];
  logic                  slotCapture [NUM_SLOTS];
  logic [NUM_FIELDS-1:0] cmbTag      [NUM_SLOTS];
  logic [OPC_W-1:0]      cmbOpcode   [NUM_SLOTS];
  logic [CNT_W-1:0]      cmbCount    [NUM_SLOTS];
  logic [NUM_REGS-1:0]   cmbRead     [NUM_SLOTS];
  logic [NUM_REGS-1:0]   cmbWrite    [NUM_SLOTS];

  logic                  qValid  [NUM_SLOTS];
  logic [NUM_FIELDS-1:0] qTag    [NUM_SLOTS];
  logic [OPC_W-1:0]      qOpcode [NUM_SLOTS];
  logic [CNT_W-1:0]      qCount  [NUM_SLOTS];
  logic [NUM_REGS-1:0]   qRead   [NUM_SLOTS];
  logic [NUM_REGS-1:0]   qWrite  [NUM_SLOTS];

  assign slotInstr[0]   = instrA;
  assign slotInstr[1]   = instrB;
  assign slotCapture[0] = strobes.captureA;
  assign slotCapture[1] = strobes.captureB;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    field_decoder #(
      .FIELD_W   (FIELD_W),
      .NUM_FIELDS(NUM_FIELDS)
    ) i_field_decoder (
      .instr      (slotInstr[s]),
      .tagOut     (cmbTag[s]),
      .opcodeOut  (cmbOpcode[s]),
      .regCountOut(cmbCount[s]),
      .readSetOut (cmbRead[s]),
      .writeSetOut(cmbWrite[s])
    );

    // R7: one output stage; an invalid slot loads zeros
    always_ff @(posedge clk) begin
      if (!rst_n || !slotCapture[s]) begin
        qValid[s]  <= 1'b0;
        qTag[s]    <= '0;
        qOpcode[s] <= '0;
        qCount[s]  <= '0;
        qRead[s]   <= '0;
        qWrite[s]  <= '0;
      end else begin
        qValid[s]  <= 1'b1;
        qTag[s]    <= cmbTag[s];
        qOpcode[s] <= cmbOpcode[s];
        qCount[s]  <= cmbCount[s];
        qRead[s]   <= cmbRead[s];
        qWrite[s]  <= cmbWrite[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depFlag   <= 1'b0;
      dualIssue <= 1'b0;
    end else begin
      depFlag   <= strobes.rawHit;
      dualIssue <= strobes.grantPair;
    end
  end

  assign writeSetACmb = cmbWrite[0];
  assign readSetBCmb  = cmbRead[1];
  assign writeSetBCmb = cmbWrite[1];

  assign decValidA = qValid[0];
  assign tagA      = qTag[0];
  assign opcodeA   = qOpcode[0];
  assign regCountA = qCount[0];
  assign readSetA  = qRead[0];
  assign writeSetA = qWrite[0];
  assign decValidB = qValid[1];
  assign tagB      = qTag[1];
  assign opcodeB   = qOpcode[1];
  assign regCountB = qCount[1];
  assign readSetB  = qRead[1];
  assign writeSetB = qWrite[1];

  // Checks on the registered results
  assert_pair_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dualIssue |-> (decValidA && decValidB));
  assert_pair_no_raw_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dualIssue |-> ((writeSetA & readSetB) == '0));
  assert_pair_no_waw_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dualIssue |-> ((writeSetA & writeSetB) == '0));
  assert_dep_has_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    depFlag |-> (decValidA && decValidB && ((writeSetA & readSetB) != '0)));
  assert_dep_blocks_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    depFlag |-> !dualIssue);
  assert_single_reg_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (decValidA && regCountA == CNT_W'(1)) |-> (readSetA == writeSetA && $countones(readSetA) == 1));
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    decValidA |-> (regCountA == CNT_W'($countones(~tagA))));
  assert_invalid_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !decValidB |-> (tagB == '0 && opcodeB == '0 && readSetB == '0 && writeSetB == '0));

endmodule

// File: rtl/tagged_pair_decoder.sv
module tagged_pair_decoder
  import tagged_pair_pkg::*;
#(
  parameter int FIELD_W    = 4,
  parameter int NUM_FIELDS = 4,
  localparam int REG_W    = FIELD_W - 1,
  localparam int NUM_REGS = 1 << REG_W,
  localparam int OPC_W    = NUM_FIELDS * REG_W,
  localparam int INSTR_W  = NUM_FIELDS * FIELD_W,
  localparam int CNT_W    = $clog2(NUM_FIELDS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [INSTR_W-1:0]    instrA,
  input  logic                  validA,
  input  logic [INSTR_W-1:0]    instrB,
  input  logic                  validB,
  output logic                  decValidA,
  output logic [NUM_FIELDS-1:0] tagA,
  output logic [OPC_W-1:0]      opcodeA,
  output logic [CNT_W-1:0]      regCountA,
  output logic [NUM_REGS-1:0]   readSetA,
  output logic [NUM_REGS-1:0]   writeSetA,
  output logic                  decValidB,
  output logic [NUM_FIELDS-1:0] tagB,
  output logic [OPC_W-1:0]      opcodeB,
  output logic [CNT_W-1:0]      regCountB,
  output logic [NUM_REGS-1:0]   readSetB,
  output logic [NUM_REGS-1:0]   writeSetB,
  output logic                  depFlag,
  output logic                  dualIssue
);

  pairStrobes_t        strobes;
  logic [NUM_REGS-1:0] writeSetACmb;
  logic [NUM_REGS-1:0] readSetBCmb;
  logic [NUM_REGS-1:0] writeSetBCmb;

  pair_control #(.NUM_REGS(NUM_REGS)) i_pair_control (
    .validA   (validA),
    .validB   (validB),
    .writeSetA(writeSetACmb),
    .readSetB (readSetBCmb),
    .writeSetB(writeSetBCmb),
    .strobes  (strobes)
  );

  decode_datapath #(
    .FIELD_W   (FIELD_W),
    .NUM_FIELDS(NUM_FIELDS)
  ) i_decode_datapath (
    .clk         (clk),
    .rst_n       (rst_n),
    .instrA      (instrA),
    .instrB      (instrB),
    .strobes     (strobes),
    .writeSetACmb(writeSetACmb),
    .readSetBCmb (readSetBCmb),
    .writeSetBCmb(writeSetBCmb),
    .decValidA   (decValidA),
    .tagA        (tagA),
    .opcodeA     (opcodeA),
    .regCountA   (regCountA),
    .readSetA    (readSetA),
    .writeSetA   (writeSetA),
    .decValidB   (decValidB),
    .tagB        (tagB),
    .opcodeB     (opcodeB),
    .regCountB   (regCountB),
    .readSetB    (readSetB),
    .writeSetB   (writeSetB),
    .depFlag     (depFlag),
    .dualIssue   (dualIssue)
  );

endmodule

// File: tb/test_tagged_pair_decoder.sv
module test_tagged_pair_decoder;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] instrA = '0, instrB = '0;
  logic validA = 1'b0, validB = 1'b0;
  logic        decValidA, decValidB, depFlag, dualIssue;
  logic [3:0]  tagA, tagB;
  logic [11:0] opcodeA, opcodeB;
  logic [2:0]  regCountA, regCountB;
  logic [7:0]  readSetA, writeSetA, readSetB, writeSetB;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  tagged_pair_decoder i_tagged_pair_decoder (
    .clk(clk), .rst_n(rst_n),
    .instrA(instrA), .validA(validA), .instrB(instrB), .validB(validB),
    .decValidA(decValidA), .tagA(tagA), .opcodeA(opcodeA), .regCountA(regCountA),
    .readSetA(readSetA), .writeSetA(writeSetA),
    .decValidB(decValidB), .tagB(tagB), .opcodeB(opcodeB), .regCountB(regCountB),
    .readSetB(readSetB), .writeSetB(writeSetB),
    .depFlag(depFlag), .dualIssue(dualIssue)
  );

  typedef struct packed {
    logic [3:0]  tag;
    logic [11:0] opc;
    logic [2:0]  cnt;
    logic [7:0]  rd;
    logic [7:0]  wr;
  } decoded_t;

  // Model written from the requirements
  function automatic decoded_t model(input logic [15:0] w);
    decoded_t d;
    int pos;
    int lowOp;
    int nReg;
    logic [3:0] f;
    d = '0;
    pos = 11;
    lowOp = -1;
    nReg = 0;
    for (int k = 3; k >= 0; k--) begin
      f = w[4*k +: 4];
      d.tag[k] = f[3];
      if (f[3]) begin
        d.opc[pos -: 3] = f[2:0];
        pos = pos - 3;
      end else begin
        nReg++;
      end
    end
    for (int k = 0; k < 4; k++) begin
      if (lowOp < 0 && d.tag[k]) lowOp = k;
    end
    d.cnt = 3'(nReg);
    for (int k = 0; k < 4; k++) begin
      f = w[4*k +: 4];
      if (!f[3]) begin
        if (nReg == 1) begin
          d.rd[f[2:0]] = 1'b1;
          d.wr[f[2:0]] = 1'b1;
        end else if (lowOp < 0) begin
          if (k >= 2) d.rd[f[2:0]] = 1'b1;
          else        d.wr[f[2:0]] = 1'b1;
        end else begin
          if (k > lowOp) d.rd[f[2:0]] = 1'b1;
          if (k < lowOp) d.wr[f[2:0]] = 1'b1;
        end
      end
    end
    return d;
  endfunction

  function automatic string set_req(input decoded_t d);
    if (d.tag == 4'h0) return "R5";
    if (d.cnt == 3'd1) return "R6";
    return "R4";
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_slot(input string slot, input logic vIn, input logic [15:0] w,
                            input logic vOut, input logic [3:0] t, input logic [11:0] o,
                            input logic [2:0] c, input logic [7:0] r, input logic [7:0] wr);
    decoded_t e;
    e = vIn ? model(w) : '0;
    check("R7", {slot, " valid"}, int'(vOut), int'(vIn));
    check("R1", {slot, " tag"}, int'(t), int'(e.tag));
    check("R2", {slot, " opcode"}, int'(o), int'(e.opc));
    check("R3", {slot, " count"}, int'(c), int'(e.cnt));
    check(set_req(e), {slot, " read set"}, int'(r), int'(e.rd));
    check(set_req(e), {slot, " write set"}, int'(wr), int'(e.wr));
  endtask

  // Present a pair at a falling edge, check at the next falling edge
  task automatic run_pair(input logic [15:0] a, input logic va,
                          input logic [15:0] b, input logic vb);
    decoded_t ea, eb;
    logic expDep, expDual;
    instrA = a; validA = va; instrB = b; validB = vb;
    @(negedge clk);
    ea = model(a);
    eb = model(b);
    expDep  = va && vb && ((ea.wr & eb.rd) != 0);
    expDual = va && vb && ((ea.wr & eb.rd) == 0) && ((ea.wr & eb.wr) == 0);
    check_slot("A", va, a, decValidA, tagA, opcodeA, regCountA, readSetA, writeSetA);
    check_slot("B", vb, b, decValidB, tagB, opcodeB, regCountB, readSetB, writeSetB);
    check("R8", "depFlag", int'(depFlag), int'(expDep));
    check("R9", "dualIssue", int'(dualIssue), int'(expDual));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int seed;
    logic [15:0] ra, rb;
    seed = 32'h1234ABCD;
    void'($urandom(seed));

    // Reset state, R7
    instrA = 16'h0123; validA = 1'b1; instrB = 16'h4567; validB = 1'b1;
    repeat (3) @(negedge clk);
    check("R7", "reset decValidA", int'(decValidA), 0);
    check("R7", "reset decValidB", int'(decValidB), 0);
    check("R7", "reset opcodeA", int'(opcodeA), 0);
    check("R7", "reset readSetB", int'(readSetB), 0);
    check("R7", "reset dualIssue", int'(dualIssue), 0);
    rst_n = 1'b1;

    // Directed corner cases
    run_pair(16'h0123, 1'b1, 16'hFFFF, 1'b1);  // R5 all registers, R2 all opcode
    check("R5", "all-register read set", int'(readSetA), 8'h03);
    check("R5", "all-register write set", int'(writeSetA), 8'h0C);
    check("R2", "all-opcode value", int'(opcodeB), 12'hFFF);
    run_pair(16'h8A5C, 1'b1, 16'hB0C9, 1'b1);  // R6 single register; R2 packing
    check("R6", "single register both sets", int'(writeSetA), 8'h20);
    check("R2", "separated opcode packing", int'(opcodeA), 12'h0A0);
    run_pair(16'h12F3, 1'b1, 16'h3F45, 1'b1);  // R8 RAW
    check("R8", "raw pair dependency", int'(depFlag), 1);
    run_pair(16'h12F3, 1'b1, 16'h4F53, 1'b1);  // R9 WAW only
    check("R9", "waw pair blocked", int'(dualIssue), 0);
    check("R8", "waw pair no dependency", int'(depFlag), 0);
    run_pair(16'h12F3, 1'b1, 16'h4F56, 1'b1);  // R9 independent
    check("R9", "independent pair granted", int'(dualIssue), 1);
    run_pair(16'h12F3, 1'b1, 16'h4F56, 1'b0);  // R9 slot B invalid
    check("R9", "B invalid no grant", int'(dualIssue), 0);
    run_pair(16'h12F3, 1'b0, 16'h3F45, 1'b1);  // R7 slot A invalid
    check("R7", "A invalid cleared write set", int'(writeSetA), 0);
    run_pair(16'hF012, 1'b1, 16'h012F, 1'b1);  // R4 all outputs / all inputs

    // R10: same word after unrelated history must decode the same
    run_pair(16'h9273, 1'b1, 16'h5C1E, 1'b1);
    run_pair(16'hFFFF, 1'b0, 16'h0000, 1'b1);
    run_pair(16'h9273, 1'b1, 16'h5C1E, 1'b1);
    check("R10", "repeat decode readSetA", int'(readSetA), int'(model(16'h9273).rd));

    // Random mix
    for (int n = 0; n < 400; n++) begin
      ra = 16'($urandom);
      rb = 16'($urandom);
      run_pair(ra, ($urandom % 8) != 0, rb, ($urandom % 8) != 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule